// File: doc/BRIEF.md
# Bounded Voltage-Step Setpoint Controller

This block holds the 5-bit output-voltage code for one buck regulator while the regulator runs in an adaptive stepping mode. Software loads a starting setpoint. That setpoint becomes the baseline. A control loop outside the block then nudges the code one step up or down. Two programmable stops bound those nudges. Each stop is stored as 4 bits and widened to a full 5-bit code by a fixed most-significant bit.

A standby request comes from two asynchronous pins. It overrides the code with a separate standby value once a programmable delay has run out. When the request is released, the code returns to the last written baseline, and every step taken since that write is lost. Setpoint writes arrive over a valid/ready stream. The block is always ready, so `sp_wr_ready` is held high and a write is accepted in any cycle where `sp_wr_valid` is high. All other pins are plain control and status.

Top module: `vstep_setpoint`

## Requirements
- R1: The lower stop is the 4-bit lower-stop register with a 0 placed above it as bit 4. After reset the register holds 4'b1000, so the lower stop is 5'b01000. A lower-stop write takes effect for steps from the next cycle.
- R2: The upper stop is the 4-bit upper-stop register with a 1 placed above it as bit 4. After reset the register holds 4'b1010, so the upper stop is 5'b11010. An upper-stop write takes effect for steps from the next cycle.
- R3: Outside standby, a lone up request raises `vcode` by one on the next cycle, but only when `vcode` is below the upper stop. A lone down request lowers it by one, but only when `vcode` is above the lower stop. Otherwise the request is ignored and `vcode` holds.
- R4: An up request and a down request in the same cycle leave `vcode` unchanged.
- R5: An accepted setpoint write appears on `vcode` on the next cycle and becomes the new baseline. The value is loaded as written, even when it lies outside the stops. A write has priority over a step request in the same cycle.
- R6: The standby request is the OR of `stby_pin_a` and `stby_pin_b`. Each pin passes through a two-flop synchroniser. If a pin rises just after a clock edge, `stby_active` is high after rising edge number `stby_dly`+4, counting from that edge.
- R7: While `stby_active` is high, `vcode` equals `stby_code`, and step requests have no effect.
- R8: If the pins fall just after an edge, `stby_active` clears on the third rising edge. On that same edge `vcode` returns to the baseline from the most recent setpoint write, including a write made during standby. All step offsets are discarded.
- R9: If the request drops before the delay has expired, standby is cancelled. A later rise restarts the full delay.
- R10: In reset, `vcode` is 5'b10000, `stby_active` is low and `sp_wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sp_wr_valid | input | 1 | Setpoint write valid |
| sp_wr_data | input | 5 | Setpoint code to load |
| sp_wr_ready | output | 1 | Always high; writes are never stalled |
| lo_wr_en | input | 1 | Load the lower-stop register |
| lo_wr_data | input | 4 | Lower-stop register value |
| hi_wr_en | input | 1 | Load the upper-stop register |
| hi_wr_data | input | 4 | Upper-stop register value |
| step_up | input | 1 | Request one step up |
| step_dn | input | 1 | Request one step down |
| stby_pin_a | input | 1 | Asynchronous standby pin A |
| stby_pin_b | input | 1 | Asynchronous standby pin B |
| stby_dly | input | 8 | Standby delay in cycles |
| stby_code | input | 5 | Code used during standby |
| vcode | output | 5 | Effective output voltage code |
| stby_active | output | 1 | Standby override in force |

## Verification
The assertions check these behaviours on every cycle: a step never carries the code past a stop it was inside, opposing requests hold the code, an accepted write shows up one cycle later, and the exit from standby lands on the last written baseline. The bench scenarios show the rest. Those are the decoded reset values of both stops, the exact latency from a pin change to standby entry and exit for several delays, and a cancelled delay that restarts. They also show that steps taken before or during standby leave no trace once standby ends.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
  typedef enum logic [1:0] {
    SB_IDLE = 2'd0,
    SB_WAIT = 2'd1,
    SB_ACT  = 2'd2
  } sb_state_e;
endpackage

// File: rtl/vstep_sync.sv
module vstep_sync #(
  parameter int N_PINS = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  output logic              req
);
  logic [N_PINS-1:0] synced;

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], pin_in[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  assign req = |synced;
endmodule

// File: rtl/vstep_stby_timer.sv
module vstep_stby_timer
  import vstep_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [DLY_W-1:0] dly,
  output logic             active,
  output logic             exit_pulse
);
  sb_state_e        state;
  logic [DLY_W-1:0] cnt;
  logic             req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SB_IDLE;
      cnt   <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= req;
      case (state)
        SB_IDLE: if (req && !req_q) begin
          cnt   <= dly;
          state <= SB_WAIT;
        end
        SB_WAIT: begin
          if (!req)           state <= SB_IDLE;
          else if (cnt == '0) state <= SB_ACT;
          else                cnt   <= cnt - 1'b1;
        end
        SB_ACT:  if (!req) state <= SB_IDLE;
        default: state <= SB_IDLE;
      endcase
    end
  end

  assign active     = (state == SB_ACT);
  assign exit_pulse = (state == SB_ACT) && !req;
endmodule

// File: rtl/vstep_step_core.sv
module vstep_step_core #(
  parameter int              CODE_W   = 5,
  parameter logic [CODE_W-1:0] RST_CODE = 5'b10000,
  parameter logic [CODE_W-2:0] RST_LO   = 4'b1000,
  parameter logic [CODE_W-2:0] RST_HI   = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              lo_wr_en,
  input  logic [CODE_W-2:0] lo_wr_data,
  input  logic              hi_wr_en,
  input  logic [CODE_W-2:0] hi_wr_data,
  input  logic              step_up,
  input  logic              step_dn,
  input  logic              hold,
  input  logic              restore,
  output logic [CODE_W-1:0] norm_code,
  output logic [CODE_W-1:0] lo_code,
  output logic [CODE_W-1:0] hi_code
);
  localparam int STOP_W = CODE_W - 1;

  logic [STOP_W-1:0] lo_reg, hi_reg;
  logic [CODE_W-1:0] base;
  logic              go_up, go_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_reg <= RST_LO;
      hi_reg <= RST_HI;
    end else begin
      if (lo_wr_en) lo_reg <= lo_wr_data;
      if (hi_wr_en) hi_reg <= hi_wr_data;
    end
  end

  assign lo_code = {1'b0, lo_reg};
  assign hi_code = {1'b1, hi_reg};

  assign go_up = step_up && !step_dn && !hold && (norm_code < hi_code);
  assign go_dn = step_dn && !step_up && !hold && (norm_code > lo_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base      <= RST_CODE;
      norm_code <= RST_CODE;
    end else if (wr_fire) begin
      base      <= wr_data;
      norm_code <= wr_data;
    end else if (restore) begin
      norm_code <= base;
    end else if (go_up) begin
      norm_code <= norm_code + 1'b1;
    end else if (go_dn) begin
      norm_code <= norm_code - 1'b1;
    end
  end
endmodule

// File: rtl/vstep_setpoint.sv
module vstep_setpoint #(
  parameter int                CODE_W   = 5,
  parameter int                DLY_W    = 8,
  parameter int                N_PINS   = 2,
  parameter int                SYNC_STG = 2,
  parameter logic [CODE_W-1:0] RST_CODE = 5'b10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sp_wr_valid,
  input  logic [CODE_W-1:0] sp_wr_data,
  output logic              sp_wr_ready,
  input  logic              lo_wr_en,
  input  logic [CODE_W-2:0] lo_wr_data,
  input  logic              hi_wr_en,
  input  logic [CODE_W-2:0] hi_wr_data,
  input  logic              step_up,
  input  logic              step_dn,
  input  logic              stby_pin_a,
  input  logic              stby_pin_b,
  input  logic [DLY_W-1:0]  stby_dly,
  input  logic [CODE_W-1:0] stby_code,
  output logic [CODE_W-1:0] vcode,
  output logic              stby_active
);
  logic              req, exit_pulse, wr_fire;
  logic [CODE_W-1:0] norm_code, lo_code, hi_code;

  assign sp_wr_ready = 1'b1;
  assign wr_fire     = sp_wr_valid && sp_wr_ready;

  vstep_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in({stby_pin_b, stby_pin_a}), .req(req)
  );

  vstep_stby_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .req(req), .dly(stby_dly),
    .active(stby_active), .exit_pulse(exit_pulse)
  );

  vstep_step_core #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_core (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_data(sp_wr_data),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
    .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
    .step_up(step_up), .step_dn(step_dn), .hold(stby_active),
    .restore(exit_pulse), .norm_code(norm_code),
    .lo_code(lo_code), .hi_code(hi_code)
  );

  assign vcode = stby_active ? stby_code : norm_code;
endmodule

// File: rtl/vstep_setpoint_chk.sv
module vstep_setpoint_chk #(
  parameter int                CODE_W   = 5,
  parameter logic [CODE_W-1:0] RST_CODE = 5'b10000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sp_wr_valid,
  input logic [CODE_W-1:0] sp_wr_data,
  input logic              step_up,
  input logic              step_dn,
  input logic              lo_wr_en,
  input logic              hi_wr_en,
  input logic [CODE_W-1:0] vcode,
  input logic              stby_active,
  input logic [CODE_W-1:0] lo_code,
  input logic [CODE_W-1:0] hi_code
);
  logic [CODE_W-1:0] last_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           last_wr <= RST_CODE;
    else if (sp_wr_valid) last_wr <= sp_wr_data;
  end

  a_r3_stay_below_max: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_active && !sp_wr_valid && !hi_wr_en && vcode <= hi_code)
    |=> (stby_active || vcode <= $past(hi_code)));

  a_r3_stay_above_min: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_active && !sp_wr_valid && !lo_wr_en && vcode >= lo_code)
    |=> (stby_active || vcode >= $past(lo_code)));

  a_r4_opposing_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && step_dn && !sp_wr_valid && !stby_active)
    |=> (stby_active || $stable(vcode)));

  a_r5_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr_valid && !stby_active)
    |=> (stby_active || vcode == $past(sp_wr_data)));

  a_r8_exit_to_baseline: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stby_active) |-> (vcode == last_wr));
endmodule

bind vstep_setpoint vstep_setpoint_chk #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sp_wr_valid(sp_wr_valid), .sp_wr_data(sp_wr_data),
  .step_up(step_up), .step_dn(step_dn), .lo_wr_en(lo_wr_en), .hi_wr_en(hi_wr_en),
  .vcode(vcode), .stby_active(stby_active), .lo_code(lo_code), .hi_code(hi_code)
);

// File: tb/vstep_setpoint_bench.sv
module vstep_setpoint_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sp_wr_valid = 1'b0;
  logic [4:0] sp_wr_data = '0;
  logic       sp_wr_ready;
  logic       lo_wr_en = 1'b0, hi_wr_en = 1'b0;
  logic [3:0] lo_wr_data = '0, hi_wr_data = '0;
  logic       step_up = 1'b0, step_dn = 1'b0;
  logic       stby_pin_a = 1'b0, stby_pin_b = 1'b0;
  logic [7:0] stby_dly = '0;
  logic [4:0] stby_code = '0;
  logic [4:0] vcode;
  logic       stby_active;

  int  checks = 0, failures = 0, cyc = 0;
  bit  done = 1'b0;

  typedef struct {
    int         due;
    logic [4:0] val;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vstep_setpoint u_vstep_setpoint (
    .clk(clk), .rst_n(rst_n), .sp_wr_valid(sp_wr_valid), .sp_wr_data(sp_wr_data),
    .sp_wr_ready(sp_wr_ready), .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
    .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data), .step_up(step_up),
    .step_dn(step_dn), .stby_pin_a(stby_pin_a), .stby_pin_b(stby_pin_b),
    .stby_dly(stby_dly), .stby_code(stby_code), .vcode(vcode),
    .stby_active(stby_active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares each scoreboard item in its due cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(vcode == e.val, e.tag, vcode, e.val);
    end
  end

  // driver: one cycle of stimulus, expected code pushed to the scoreboard
  task automatic drive(input bit wr, input logic [4:0] d, input bit up, input bit dn,
                       input logic [4:0] exp, input string tag);
    exp_t e;
    @(posedge clk); #1;
    sp_wr_valid = wr; sp_wr_data = d; step_up = up; step_dn = dn;
    e.due = cyc + 1; e.val = exp; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    sp_wr_valid = 1'b0; step_up = 1'b0; step_dn = 1'b0;
  endtask

  task automatic set_stops(input bit lo, input logic [3:0] lv, input bit hi, input logic [3:0] hv);
    @(posedge clk); #1;
    lo_wr_en = lo; lo_wr_data = lv; hi_wr_en = hi; hi_wr_data = hv;
    @(posedge clk); #1;
    lo_wr_en = 1'b0; hi_wr_en = 1'b0;
  endtask

  task automatic edges_until(input bit level, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (stby_active != level && n < 400);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(vcode == 5'b10000, "R10 reset code", vcode, 16);
    check(!stby_active, "R10 reset standby", stby_active, 0);
    check(sp_wr_ready, "R10 ready", sp_wr_ready, 1);
    @(posedge clk); #1 rst_n = 1'b1;

    // default stops
    drive(1, 5'd26, 0, 0, 5'd26, "R5 write 26");
    drive(0, 0, 1, 0, 5'd26, "R2 default max 11010 blocks up");
    drive(0, 0, 0, 1, 5'd25, "R3 down from 26");
    drive(1, 5'd8, 0, 0, 5'd8, "R5 write 8");
    drive(0, 0, 0, 1, 5'd8, "R1 default min 01000 blocks down");
    drive(0, 0, 1, 0, 5'd9, "R3 up from 8");
    // plain stepping
    drive(1, 5'd12, 0, 0, 5'd12, "R5 write 12");
    drive(0, 0, 1, 0, 5'd13, "R3 up");
    drive(0, 0, 1, 0, 5'd14, "R3 up again");
    drive(0, 0, 0, 1, 5'd13, "R3 down");
    drive(0, 0, 1, 1, 5'd13, "R4 opposing requests");
    // programmed stops: max 10000 = 16, min 01111 = 15
    set_stops(0, 0, 1, 4'b0000);
    drive(1, 5'd15, 0, 0, 5'd15, "R5 write 15");
    drive(0, 0, 1, 0, 5'd16, "R2 up to new max");
    drive(0, 0, 1, 0, 5'd16, "R2 new max blocks");
    set_stops(1, 4'b1111, 0, 0);
    drive(0, 0, 0, 1, 5'd15, "R1 down to new min");
    drive(0, 0, 0, 1, 5'd15, "R1 new min blocks");
    // writes outside the stops
    drive(1, 5'd30, 0, 0, 5'd30, "R5 write above max loads as written");
    drive(0, 0, 1, 0, 5'd30, "R3 up ignored above max");
    drive(0, 0, 0, 1, 5'd29, "R3 down allowed above max");
    drive(1, 5'd2, 0, 0, 5'd2, "R5 write below min loads as written");
    drive(0, 0, 0, 1, 5'd2, "R3 down ignored below min");
    drive(0, 0, 1, 0, 5'd3, "R3 up allowed below min");
    drive(1, 5'd10, 1, 0, 5'd10, "R5 write wins over step");
    set_stops(1, 4'b1000, 1, 4'b1010);

    // standby with delay 3
    drive(1, 5'd20, 0, 0, 5'd20, "R5 write 20");
    drive(0, 0, 1, 0, 5'd21, "R3 up before standby");
    @(posedge clk); #1;
    stby_code = 5'd5; stby_dly = 8'd3; stby_pin_a = 1'b1;
    edges_until(1'b1, n);
    check(n == 7, "R6 entry latency delay 3", n, 7);
    check(vcode == 5'd5, "R7 standby code", vcode, 5);
    drive(0, 0, 1, 0, 5'd5, "R7 step ignored in standby");
    drive(0, 0, 1, 0, 5'd5, "R7 step ignored in standby 2");
    @(posedge clk); #1 stby_pin_a = 1'b0;
    edges_until(1'b0, n);
    check(n == 3, "R8 exit latency", n, 3);
    check(vcode == 5'd20, "R8 back to baseline", vcode, 20);
    settle();

    // pin B, zero delay, write during standby
    @(posedge clk); #1;
    stby_dly = 8'd0; stby_pin_b = 1'b1;
    edges_until(1'b1, n);
    check(n == 4, "R6 entry latency pin b delay 0", n, 4);
    drive(1, 5'd7, 0, 0, 5'd5, "R7 write held under standby");
    @(posedge clk); #1 stby_pin_b = 1'b0;
    edges_until(1'b0, n);
    check(vcode == 5'd7, "R8 baseline from write in standby", vcode, 7);
    settle();

    // cancelled delay and restart
    @(posedge clk); #1;
    stby_dly = 8'd10; stby_pin_a = 1'b1;
    repeat (5) @(posedge clk);
    #1 stby_pin_a = 1'b0;
    repeat (14) @(posedge clk);
    @(negedge clk);
    check(!stby_active, "R9 cancelled before expiry", stby_active, 0);
    check(vcode == 5'd7, "R9 code unchanged by cancel", vcode, 7);
    @(posedge clk); #1 stby_pin_a = 1'b1;
    edges_until(1'b1, n);
    check(n == 14, "R9 full delay after restart", n, 14);
    @(posedge clk); #1 stby_pin_a = 1'b0;
    edges_until(1'b0, n);
    settle();

    if (sb.size() != 0) check(0, "scoreboard drained", sb.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end
endmodule